// File: doc/BRIEF.md
# Oversampled Teletext Bit Recovery

This block takes the output of a video comparator, already reduced to one digital bit, and samples it at four times the teletext data rate. There is no clock recovery. The bit rate is held tightly enough that a fixed phase grid of four samples per bit stays aligned for a whole packet. Incoming samples are shifted without a break through a window that spans the complete start-of-packet sequence. When the window holds that sequence, the block locks its bit grid to the detection point. From then on it takes one sample from the centre of each following bit and packs the bits into bytes, least significant bit first.

A frame-valid output stays high for the whole packet. Every completed byte raises a one-cycle byte-valid strobe. After a fixed number of bytes the block drops frame-valid and returns to hunting for the next start sequence. Colour burst, line numbering and analogue slicing are left to other logic. A single clock enable marks which clock cycles carry a sample.

Top module: `txt_bit_recovery`

## Requirements
- R1: While reset is applied, and after it is released until a start sequence has been matched, frame_vld, byte_vld and byte_out are all 0.
- R2: The start sequence is 24 bits in time order. It begins with 16 run-in bits that alternate starting with 1, followed by the framing byte 0xE4 sent least significant bit first (0,0,1,0,0,1,1,1). Each bit occupies 4 consecutive enabled samples. frame_vld rises on the clock edge after the enabled sample that completes the last framing bit.
- R3: In matching, the first of the 4 samples of each bit is ignored. The other three samples of every bit must all equal that bit's value, otherwise no packet is declared.
- R4: After a match, each data bit is the value of the third enabled sample (index 2 of 0..3) of that bit. The other three samples have no effect on the recovered byte.
- R5: Data bits fill each byte from bit 0 to bit 7. byte_out takes the new byte and byte_vld is high for exactly one clock, in the cycle after the enabled sample carrying the centre of bit 7. byte_out changes at no other time.
- R6: Exactly 42 bytes are delivered per packet. frame_vld falls on the edge of the last enabled sample of the 42nd byte. The detector then matches new start sequences again.
- R7: A start sequence that appears while frame_vld is high is ignored. The packet keeps its length and content.
- R8: Clock cycles with smp_en low change no state: the window, bit phase, counters, frame_vld and byte_out hold, and byte_vld is 0 in the following cycle.
- R9: byte_vld is only ever high while frame_vld is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each enabled cycle carries one sample |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_en | input | 1 | High in cycles that carry a valid sample |
| smp_in | input | 1 | Comparator-sliced video sample |
| byte_out | output | 8 | Last recovered byte, LSB received first |
| byte_vld | output | 1 | One-cycle strobe when byte_out holds a new byte |
| frame_vld | output | 1 | High from start-sequence match until the last byte of the packet |

## Verification
On every cycle the bound checker watches four things. byte_vld must lie inside frame_vld and never lasts two cycles. byte_out may change only with a strobe. Cycles without a sample must leave the frame state untouched. A companion counter confirms that each frame closes after exactly 42 strobes. The checker cannot see the sample-level matching: which sample of a bit is ignored, which one becomes the data bit, and whether a start sequence buried in the payload restarts the packet. The bench shows these through a cycle-accurate behavioural model and through stimuli that corrupt individual sample positions, embed the start sequence in the payload, and insert gaps between samples.

// File: rtl/txt_rx_pkg.sv
package txt_rx_pkg;

  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_DATA = 1'b1
  } rx_state_e;

  // Value of bit j (time order) of the start sequence: alternating
  // run-in beginning with 1, then the framing code LSB first.
  function automatic logic start_bit(input int j, input int runin,
                                     input logic [7:0] code);
    if (j < runin) return (j % 2 == 0);
    return code[j - runin];
  endfunction

endpackage

// File: rtl/txt_start_match.sv
module txt_start_match
  import txt_rx_pkg::*;
#(
  parameter int         OSR        = 4,
  parameter int         RUNIN_BITS = 16,
  parameter logic [7:0] FRAME_CODE = 8'hE4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic smp_in,
  output logic hit
);
  localparam int NBITS = RUNIN_BITS + 8;
  localparam int WIN   = NBITS * OSR;
  localparam int NCMP  = NBITS * (OSR - 1);

  logic [WIN-1:0]  win_q, win_d;
  logic [NCMP-1:0] agree;

  // newest sample enters at the top; index 0 is the oldest sample
  always_comb begin
    win_d = win_q;
    if (smp_en) win_d = {smp_in, win_q[WIN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  // sample 0 of each bit sits on the transition and is skipped
  for (genvar j = 0; j < NBITS; j++) begin : g_bit
    for (genvar s = 1; s < OSR; s++) begin : g_smp
      localparam logic WANT = start_bit(j, RUNIN_BITS, FRAME_CODE);
      assign agree[j*(OSR-1) + s - 1] = (win_d[j*OSR + s] == WANT);
    end
  end

  assign hit = smp_en & (&agree);

endmodule

// File: rtl/txt_bit_slicer.sv
module txt_bit_slicer #(
  parameter int OSR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic active,
  input  logic start,
  output logic take,
  output logic last
);
  localparam int PW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (start) begin
      ph_d = '0;
    end else if (smp_en && active) begin
      ph_d = (ph_q == PW'(OSR - 1)) ? '0 : ph_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign take = smp_en & active & (ph_q == PW'(MID));
  assign last = smp_en & active & (ph_q == PW'(OSR - 1));

endmodule

// File: rtl/txt_byte_packer.sv
module txt_byte_packer #(
  parameter int PKT_BYTES = 42
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       take,
  input  logic       last,
  input  logic       bit_in,
  output logic [7:0] byte_out,
  output logic       byte_vld,
  output logic       done
);
  localparam int BW = $clog2(PKT_BYTES);

  logic [2:0]    bit_q, bit_d;
  logic [BW-1:0] cnt_q, cnt_d;
  logic [7:0]    acc_q, acc_d;
  logic [7:0]    byte_q, byte_d;
  logic          vld_q, vld_d;

  assign done = last & (bit_q == 3'd7) & (cnt_q == BW'(PKT_BYTES - 1));

  always_comb begin
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    byte_d = byte_q;
    vld_d  = 1'b0;
    if (start) begin
      bit_d = '0;
      cnt_d = '0;
    end else begin
      if (take) begin
        acc_d = {bit_in, acc_q[7:1]};
        if (bit_q == 3'd7) begin
          byte_d = {bit_in, acc_q[7:1]};
          vld_d  = 1'b1;
        end
      end
      if (last) begin
        if (bit_q == 3'd7) begin
          bit_d = '0;
          cnt_d = done ? '0 : cnt_q + BW'(1);
        end else begin
          bit_d = bit_q + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
    end
  end

  assign byte_out = byte_q;
  assign byte_vld = vld_q;

endmodule

// File: rtl/txt_bit_recovery.sv
module txt_bit_recovery
  import txt_rx_pkg::*;
#(
  parameter int         OSR        = 4,
  parameter int         RUNIN_BITS = 16,
  parameter logic [7:0] FRAME_CODE = 8'hE4,
  parameter int         PKT_BYTES  = 42
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic       smp_in,
  output logic [7:0] byte_out,
  output logic       byte_vld,
  output logic       frame_vld
);
  logic [1:0] rs_q;
  logic       rst_int_n;
  rx_state_e  st_q, st_d;
  logic       hit, start, active, take, last, done;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  txt_start_match #(
    .OSR(OSR), .RUNIN_BITS(RUNIN_BITS), .FRAME_CODE(FRAME_CODE)
  ) u_match (
    .clk(clk), .rst_n(rst_int_n), .smp_en(smp_en), .smp_in(smp_in), .hit(hit)
  );

  assign active = (st_q == RX_DATA);
  assign start  = (st_q == RX_HUNT) & hit;

  txt_bit_slicer #(.OSR(OSR)) u_slice (
    .clk(clk), .rst_n(rst_int_n), .smp_en(smp_en), .active(active),
    .start(start), .take(take), .last(last)
  );

  txt_byte_packer #(.PKT_BYTES(PKT_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_int_n), .start(start), .take(take), .last(last),
    .bit_in(smp_in), .byte_out(byte_out), .byte_vld(byte_vld), .done(done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RX_HUNT: if (start) st_d = RX_DATA;
      RX_DATA: if (done)  st_d = RX_HUNT;
      default: st_d = RX_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= RX_HUNT;
    else            st_q <= st_d;
  end

  assign frame_vld = active;

endmodule

// File: rtl/txt_bit_recovery_chk.sv
module txt_bit_recovery_chk #(
  parameter int PKT_BYTES = 42
) (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_en,
  input logic [7:0] byte_out,
  input logic       byte_vld,
  input logic       frame_vld
);
  localparam int NW = $clog2(PKT_BYTES + 1);

  logic [NW-1:0] nb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            nb_q <= '0;
    else if (!frame_vld)   nb_q <= '0;
    else if (byte_vld)     nb_q <= nb_q + NW'(1);
  end

  // R9
  vld_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> frame_vld);

  // R5
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_out) |-> byte_vld);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(frame_vld) && !byte_vld));

  // R2
  rise_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_vld) |-> $past(smp_en));

  // R6
  len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_vld) |-> (nb_q == NW'(PKT_BYTES)));

  // R6
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (nb_q < NW'(PKT_BYTES)));

endmodule

bind txt_bit_recovery txt_bit_recovery_chk #(.PKT_BYTES(PKT_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .byte_out(byte_out),
  .byte_vld(byte_vld), .frame_vld(frame_vld)
);

// File: tb/sim_txt_bit_recovery.sv
module sim_txt_bit_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int NPKT       = 42;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_en = 1'b0;
  logic       smp_in = 1'b0;
  logic [7:0] byte_out;
  logic       byte_vld;
  logic       frame_vld;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  txt_bit_recovery u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_in(smp_in),
    .byte_out(byte_out), .byte_vld(byte_vld), .frame_vld(frame_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit pat_bit(input int j);
    logic [7:0] code = 8'hE4;
    if (j < 16) return (j % 2 == 0);
    return code[j - 16];
  endfunction

  // ---------------- behavioural reference model ----------------
  bit         hist[$];
  bit         m_recv;
  int         m_ph, m_bits, m_bytes;
  logic [7:0] m_acc, m_byte;
  bit         m_vld;
  logic [7:0] rx_q[$];
  bit         run_cmp = 1'b0;

  function automatic bit model_match();
    if (hist.size() < 96) return 1'b0;
    for (int j = 0; j < 24; j++)
      for (int s = 1; s < 4; s++)
        if (hist[j*4 + s] != pat_bit(j)) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      hist.delete();
      m_recv = 0; m_ph = 0; m_bits = 0; m_bytes = 0;
      m_acc = '0; m_byte = '0; m_vld = 0;
    end else begin
      m_vld = 0;
      if (smp_en) begin
        hist.push_back(smp_in);
        if (hist.size() > 96) void'(hist.pop_front());
        if (!m_recv) begin
          if (model_match()) begin
            m_recv = 1; m_ph = 0; m_bits = 0; m_bytes = 0; m_acc = '0;
          end
        end else begin
          if (m_ph == 2) begin
            m_acc[m_bits] = smp_in;
            if (m_bits == 7) begin m_byte = m_acc; m_vld = 1; end
          end
          if (m_ph == 3) begin
            m_ph = 0;
            if (m_bits == 7) begin
              m_bits = 0; m_bytes++;
              if (m_bytes == NPKT) m_recv = 0;
            end else m_bits++;
          end else m_ph++;
        end
      end
    end
    if (cyc == WD_LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(frame_vld === m_recv, "R6 frame_vld vs model", frame_vld, m_recv);
      chk(byte_vld === m_vld, "R5 byte_vld vs model", byte_vld, m_vld);
      if (m_vld) chk(byte_out === m_byte, "R4 byte_out vs model", byte_out, m_byte);
      if (byte_vld) begin
        chk(frame_vld === 1'b1, "R9 strobe inside frame", frame_vld, 1);
        rx_q.push_back(byte_out);
      end
    end
  end

  // ---------------- stimulus ----------------
  bit gappy     = 1'b0;
  bit chk_rise  = 1'b0;

  task automatic put(input bit v);
    @(negedge clk);
    if (chk_rise) begin
      chk(frame_vld === 1'b1, "R2 frame rises after last framing sample", frame_vld, 1);
      chk_rise = 1'b0;
    end
    smp_en = 1'b1; smp_in = v;
    if (gappy) begin
      @(negedge clk);
      smp_en = 1'b0; smp_in = 1'($urandom);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_en = 1'b0; smp_in = 1'($urandom);
    end
  endtask

  // mode 0 clean, 1 transition sample inverted, 2 only centre correct, 3 centre corrupted
  task automatic send_bit(input bit b, input int mode);
    case (mode)
      1:       begin put(~b); put(b);  put(b);  put(b);  end
      2:       begin put(1'($urandom)); put(~b); put(b); put(~b); end
      3:       begin put(b);  put(b);  put(~b); put(b);  end
      default: begin put(b);  put(b);  put(b);  put(b);  end
    endcase
  endtask

  task automatic send_pattern(input int mode, input int bad_bit);
    for (int j = 0; j < 24; j++) send_bit(pat_bit(j), (j == bad_bit) ? 3 : mode);
  endtask

  task automatic send_packet(input int pmode, input int dmode, input bit embed,
                             input int seed, input string tag);
    logic [7:0] exp[NPKT];
    for (int i = 0; i < NPKT; i++) exp[i] = 8'(i * 37 + seed);
    if (embed) begin exp[10] = 8'h55; exp[11] = 8'h55; exp[12] = 8'hE4; end
    rx_q.delete();
    send_pattern(pmode, -1);
    chk_rise = 1'b1;
    for (int i = 0; i < NPKT; i++)
      for (int k = 0; k < 8; k++) send_bit(exp[i][k], dmode);
    idle(6);
    chk(rx_q.size() == NPKT, {tag, " byte count"}, rx_q.size(), NPKT);
    chk(frame_vld === 1'b0, {tag, " frame dropped after last byte"}, frame_vld, 0);
    for (int i = 0; i < NPKT && i < rx_q.size(); i++)
      chk(rx_q[i] === exp[i], {tag, " byte value LSB first"}, rx_q[i], exp[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(frame_vld === 1'b0, "R1 frame_vld in reset", frame_vld, 0);
    chk(byte_vld === 1'b0, "R1 byte_vld in reset", byte_vld, 0);
    chk(byte_out === 8'h00, "R1 byte_out in reset", byte_out, 0);
    rst_n = 1'b1;
    idle(5);
    chk(frame_vld === 1'b0 && byte_vld === 1'b0 && byte_out === 8'h00,
        "R1 outputs after release", {frame_vld, byte_vld}, 0);
    run_cmp = 1'b1;

    for (int i = 0; i < 200; i++) put(1'($urandom));
    idle(3);

    // R5 R6: clean packet, then another back to back
    send_packet(0, 0, 1'b0, 5, "R5");
    send_packet(0, 0, 1'b0, 91, "R6 rearm");

    // R3: transition samples wrong still match; R4: only centre sample carries data
    send_packet(1, 2, 1'b0, 17, "R4 centre sample");

    // R3: a corrupted counted sample prevents detection
    rx_q.delete();
    send_pattern(0, 5);
    for (int i = 0; i < 20; i++) send_bit(1'b0, 0);
    idle(3);
    chk(frame_vld === 1'b0, "R3 no match with corrupt sample", frame_vld, 0);
    chk(rx_q.size() == 0, "R3 no bytes with corrupt sample", rx_q.size(), 0);
    send_pattern(0, 23);
    for (int i = 0; i < 20; i++) send_bit(1'b1, 0);
    idle(3);
    chk(frame_vld === 1'b0, "R3 no match with corrupt framing bit", frame_vld, 0);
    chk(rx_q.size() == 0, "R3 no bytes after corrupt framing bit", rx_q.size(), 0);

    // R7: start sequence embedded in the payload
    send_packet(0, 0, 1'b1, 63, "R7 embedded start");

    // R8: idle cycles between every sample
    gappy = 1'b1;
    send_packet(0, 0, 1'b0, 29, "R8 gapped samples");
    gappy = 1'b0;
    idle(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule